// File: doc/BRIEF.md
# Dual-Clock Word Buffer with Reset-Selected Write Enables

This block is a first-in first-out buffer of 9-bit words whose write side and read side run on unrelated clocks. Words enter on rising edges of the write clock and leave, in the order they came in, through a registered output on rising edges of the read clock. Two active-low enables guard the read side. An active-low output enable decides whether the registered word is presented. Active-low flags report when the buffer is empty and when it is full. Writes into a full buffer and reads from an empty buffer are dropped. After such a dropped read, the output keeps the last word that was really read.

One shared control input has two roles, and the role is fixed by its level while reset is held low. If it was high during reset, it is a second, active-high write enable beside the active-low one, which lets several buffers be chained for more depth. If it was low during reset, the block is in programmable-flag mode. In that mode the same input is a load strobe: when it is low together with the active-low write enable, no data word is stored, and a request output goes high for an offset register block outside this one.

Pointers cross between the clock domains as Gray codes through two-flop synchronisers. Full is decided in the write domain and empty in the read domain. The depth is a power-of-two parameter, 1024 by default.

Top module: `dual_clk_fifo9`

## Requirements
- R1: While `rst_n` is low the buffer is emptied: `empty_n` is low, `full_n` is high and the output register holds zero, so `q_o` reads 0 when `oe_n` is low.
- R2: The level of `wen2_ld` at the write-clock edges while `rst_n` is low is held as the mode after reset: 1 selects dual-write-enable mode, 0 selects programmable-flag mode. The mode does not change again until the next reset.
- R3: In dual-write-enable mode a word is stored on a rising `wclk` edge only when `wen1_n` is 0 and `wen2_ld` is 1. Any other combination stores nothing.
- R4: In programmable-flag mode a word is stored on a rising `wclk` edge when `wen1_n` is 0 while the load strobe `wen2_ld` is high.
- R5: A word is taken on a rising `rclk` edge only when `ren1_n` and `ren2_n` are both 0. The taken word is loaded into the output register at that edge. If only one of them is 0, the output register keeps its value.
- R6: After DEPTH words have been written and none read, `full_n` is low, and a further write is dropped: it never appears at the output.
- R7: A read attempted while `empty_n` is low is dropped and the output register keeps the last word that was validly read.
- R8: `q_o` equals the output register while `oe_n` is 0 and reads zero while `oe_n` is 1. `q_en_o` is the inverse of `oe_n`.
- R9: `ld_req_o` is high exactly when the mode is programmable-flag, `rst_n` is high, and `wen1_n` and `wen2_ld` are both 0. No data word is stored in that case. In dual-write-enable mode `ld_req_o` stays low.
- R10: Words written and read on unrelated clocks, including in overlapping cycles, come out complete and in write order. Each write or read moves its Gray-coded pointer by exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| d_i | input | 9 | Write data |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Second write enable (high) or load strobe (low), role set at reset |
| ren1_n | input | 1 | First active-low read enable |
| ren2_n | input | 1 | Second active-low read enable |
| oe_n | input | 1 | Active-low output enable |
| q_o | output | 9 | Qualified read data |
| q_en_o | output | 1 | High when `q_o` carries the output register |
| empty_n | output | 1 | Low when the buffer is empty (read domain) |
| full_n | output | 1 | Low when the buffer is full (write domain) |
| ld_req_o | output | 1 | Offset-load request in programmable-flag mode |

## Verification
A write and a read can land in the same stretch of time. Each then moves its own pointer while the other domain sees only the synchronised copy, so an empty flag may lift, or a word may be read, while another write is in flight. The bench provokes this with a 50 MHz write clock and a slower read clock running concurrent writer and reader streams. Each stream gates its requests only on the flag visible in its own domain. The scoreboard judges the outcome: every accepted word must be returned exactly once and in order, and every read refused by the empty flag must leave the output register unchanged.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
  parameter int unsigned WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic {MODE_PFLAG = 1'b0, MODE_DUALWE = 1'b1} wmode_e;
endpackage

// File: rtl/fifo9_sync.sv
module fifo9_sync #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/fifo9_ram.sv
module fifo9_ram
  import fifo9_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  localparam int unsigned ENTRIES = 1 << AW;
  word_t store [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/fifo9_wr_ctl.sv
module fifo9_wr_ctl
  import fifo9_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [AW:0]   rgray_s,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          we,
  output logic          ld_req,
  output logic          full
);
  localparam int unsigned PW = AW + 1;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // Full: the read pointer, seen from here, is one lap behind.
  function automatic logic lap_behind(input logic [PW-1:0] wg, input logic [PW-1:0] rg);
    return wg == (rg ^ {2'b11, {(PW-2){1'b0}}});
  endfunction

  wmode_e        mode_q;
  logic [PW-1:0] wbin_q, wgray_q, wbin_nx;
  logic          wr_req, wr_fire;

  // Mode is sampled on every write edge while reset is held.
  always_ff @(posedge wclk) begin
    if (!rst_n) mode_q <= wmode_e'(wen2_ld);
  end

  assign wr_req  = rst_n && !wen1_n && wen2_ld;
  assign ld_req  = rst_n && (mode_q == MODE_PFLAG) && !wen1_n && !wen2_ld;
  assign full    = lap_behind(wgray_q, rgray_s);
  assign wr_fire = wr_req && !full;
  assign wbin_nx = wbin_q + PW'(wr_fire);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= bin2gray(wbin_nx);
    end
  end

  assign waddr = wbin_q[AW-1:0];
  assign wgray = wgray_q;
  assign we    = wr_fire;

  a_r6_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_req && full) |=> $stable(wbin_q));
  a_r9_load_blocks_write: assert property (@(posedge wclk) disable iff (!rst_n)
    ld_req |-> !wr_fire);
  a_r2_mode_held: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_fire || ld_req) |=> $stable(mode_q));
  a_r10_wgray_step: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_fire |=> $countones(wgray_q ^ $past(wgray_q)) == 1);
endmodule

// File: rtl/fifo9_rd_ctl.sv
module fifo9_rd_ctl
  import fifo9_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic [AW:0]   wgray_s,
  input  word_t         rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output word_t         q_reg,
  output logic          empty
);
  localparam int unsigned PW = AW + 1;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [PW-1:0] rbin_q, rgray_q, rbin_nx;
  logic          rd_req, rd_fire;
  word_t         q_q;

  assign rd_req  = !ren1_n && !ren2_n;
  assign empty   = (rgray_q == wgray_s);
  assign rd_fire = rd_req && !empty;
  assign rbin_nx = rbin_q + PW'(rd_fire);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      q_q     <= '0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_q <= bin2gray(rbin_nx);
      if (rd_fire) q_q <= rdata;
    end
  end

  assign raddr = rbin_q[AW-1:0];
  assign rgray = rgray_q;
  assign q_reg = q_q;

  a_r7_hold_when_empty: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_req && empty) |=> $stable(q_q));
  a_r5_partial_enable_holds: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren1_n != ren2_n) |=> ($stable(q_q) && $stable(rbin_q)));
  a_r5_ptr_advance: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_fire |=> rbin_q == PW'($past(rbin_q) + 1'b1));
  a_r10_rgray_step: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_fire |=> $countones(rgray_q ^ $past(rgray_q)) == 1);
endmodule

// File: rtl/dual_clk_fifo9.sv
module dual_clk_fifo9
  import fifo9_pkg::*;
#(
  parameter int unsigned DEPTH = 1024
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] d_i,
  input  logic              wen1_n,
  input  logic              wen2_ld,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic              oe_n,
  output logic [WORD_W-1:0] q_o,
  output logic              q_en_o,
  output logic              empty_n,
  output logic              full_n,
  output logic              ld_req_o
);
  // DEPTH must be a power of two, at least 4.
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          we, full, empty;
  word_t         rdata, q_reg;

  fifo9_ram #(.AW(AW)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(d_i), .raddr(raddr), .rdata(rdata)
  );

  fifo9_wr_ctl #(.AW(AW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld), .rgray_s(rgray_s),
    .waddr(waddr), .wgray(wgray), .we(we), .ld_req(ld_req_o), .full(full)
  );

  fifo9_rd_ctl #(.AW(AW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .ren1_n(ren1_n), .ren2_n(ren2_n), .wgray_s(wgray_s),
    .rdata(rdata), .raddr(raddr), .rgray(rgray), .q_reg(q_reg), .empty(empty)
  );

  fifo9_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  fifo9_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  assign q_o     = oe_n ? '0 : q_reg;
  assign q_en_o  = !oe_n;
  assign empty_n = !empty;
  assign full_n  = !full;

  a_r8_oe_gates: assert property (@(posedge rclk) disable iff (!rst_n)
    oe_n |-> (q_o == '0 && !q_en_o));
endmodule

// File: tb/dual_clk_fifo9_bench.sv
module dual_clk_fifo9_bench;
  localparam int DEPTH = 1024;

  logic       wclk = 0, rclk = 0, rst_n = 0;
  logic [8:0] d_i = '0;
  logic       wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1, oe_n = 0;
  logic [8:0] q_o;
  logic       q_en_o, empty_n, full_n, ld_req_o;

  int n_chk = 0, n_err = 0;
  logic [8:0] exp_q[$];
  logic [8:0] last_q = '0;
  bit r_both = 0, r_nonempty = 0, m_fire = 0, m_hold = 0;

  dual_clk_fifo9 #(.DEPTH(DEPTH)) u_dual_clk_fifo9 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .d_i(d_i), .wen1_n(wen1_n),
    .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .q_o(q_o),
    .q_en_o(q_en_o), .empty_n(empty_n), .full_n(full_n), .ld_req_o(ld_req_o)
  );

  always #10 wclk = ~wclk;   // 50 MHz
  always #15 rclk = ~rclk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: decide at the read edge, compare at the following falling edge.
  always @(posedge rclk) begin
    m_fire = r_both && r_nonempty && rst_n;
    m_hold = rst_n && (!ren1_n || !ren2_n) && !(r_both && r_nonempty);
  end

  always @(negedge rclk) begin
    if (m_fire) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected word", {23'd0, q_o}, 0);
      else begin
        last_q = exp_q.pop_front();
        chk(q_o == last_q, "R5/R10 read order", {23'd0, q_o}, {23'd0, last_q});
      end
      m_fire = 0;
    end else if (m_hold) begin
      chk(q_o == last_q, "R7/R5 hold on refused read", {23'd0, q_o}, {23'd0, last_q});
      m_hold = 0;
    end
  end

  task automatic do_reset(input bit mode);
    @(negedge wclk);
    rst_n = 0; wen2_ld = mode; wen1_n = 1; ren1_n = 1; ren2_n = 1; r_both = 0;
    repeat (3) @(posedge wclk);
    repeat (2) @(posedge rclk);
    @(negedge wclk);
    chk(empty_n == 0, "R1 empty_n in reset", {31'd0, empty_n}, 0);
    chk(full_n == 1, "R1 full_n in reset", {31'd0, full_n}, 1);
    chk(q_o == 0, "R1 q_o in reset", {23'd0, q_o}, 0);
    exp_q.delete(); last_q = '0;
    rst_n = 1; wen2_ld = 1;
  endtask

  task automatic push(input logic [8:0] v);
    @(negedge wclk);
    d_i = v; wen1_n = 0; wen2_ld = 1;
    if (full_n) exp_q.push_back(v);
  endtask

  task automatic idle_w();
    @(negedge wclk);
    wen1_n = 1; wen2_ld = 1;
  endtask

  task automatic pull(input bit e1, input bit e2);
    @(negedge rclk);
    ren1_n = !e1; ren2_n = !e2; r_both = e1 && e2; r_nonempty = empty_n;
  endtask

  task automatic idle_r();
    @(negedge rclk);
    ren1_n = 1; ren2_n = 1; r_both = 0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) pull(1, 1);
    idle_r();
    repeat (2) @(negedge rclk);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int popped;
    // Dual-write-enable mode (R2)
    do_reset(1'b1);
    @(negedge wclk); wen1_n = 0; wen2_ld = 0; #1;
    chk(ld_req_o == 0, "R9 no load request in dual mode", {31'd0, ld_req_o}, 0);
    @(negedge wclk); wen1_n = 1; wen2_ld = 1;
    idle_w();
    repeat (6) @(negedge rclk);
    chk(empty_n == 0, "R3 blocked write combos store nothing", {31'd0, empty_n}, 0);

    for (int i = 0; i < 4; i++) push(9'h0A0 + 9'(i));
    idle_w();
    repeat (6) @(negedge rclk);
    chk(empty_n == 1, "R3 write accepted", {31'd0, empty_n}, 1);
    pull(1, 0); pull(0, 1); idle_r();
    chk(exp_q.size() == 4, "R5 single enable takes nothing", exp_q.size(), 4);
    drain();
    pull(1, 1); pull(1, 1); idle_r();
    chk(empty_n == 0, "R7 empty after drain", {31'd0, empty_n}, 0);

    // Output enable (R8)
    @(negedge rclk); oe_n = 1; #1;
    chk(q_o == 0 && q_en_o == 0, "R8 q_o gated off", {22'd0, q_en_o, q_o}, 0);
    @(negedge rclk); oe_n = 0; #1;
    chk(q_o == last_q && q_en_o == 1, "R8 q_o visible", {22'd0, q_en_o, q_o}, {22'd1, last_q});

    // Fill to full (R6)
    for (int i = 0; i < DEPTH; i++) push(9'(i) ^ 9'h0A5);
    idle_w();
    repeat (4) @(negedge wclk);
    chk(full_n == 0, "R6 full after DEPTH writes", {31'd0, full_n}, 0);
    push(9'h1FF);
    idle_w();
    chk(exp_q.size() == DEPTH, "R6 extra write not queued", exp_q.size(), DEPTH);
    repeat (6) @(negedge rclk);
    drain();
    pull(1, 1); pull(1, 1); idle_r();
    chk(empty_n == 0 && q_o == last_q, "R6/R7 overflow word absent, hold", {23'd0, q_o}, {23'd0, last_q});

    // Reset clears stored data (R1)
    for (int i = 0; i < 3; i++) push(9'h055 + 9'(i));
    idle_w();
    repeat (6) @(negedge rclk);
    pull(1, 1); idle_r();
    repeat (2) @(negedge rclk);

    // Programmable-flag mode (R2, R4, R9)
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) push(9'h1C0 + 9'(i));
    idle_w();
    repeat (6) @(negedge rclk);
    chk(empty_n == 1, "R4 write in programmable-flag mode", {31'd0, empty_n}, 1);
    drain();
    @(negedge wclk); wen1_n = 0; wen2_ld = 0; d_i = 9'h133; #1;
    chk(ld_req_o == 1, "R9 load request raised", {31'd0, ld_req_o}, 1);
    @(negedge wclk); wen1_n = 1; #1;
    chk(ld_req_o == 0, "R9 load request needs wen1_n", {31'd0, ld_req_o}, 0);
    idle_w();
    repeat (6) @(negedge rclk);
    chk(empty_n == 0, "R9 load cycle stores no word", {31'd0, empty_n}, 0);

    // Concurrent streams (R10)
    do_reset(1'b1);
    popped = 0;
    fork
      begin
        for (int i = 0; i < 80; i++) push(9'(i * 7 + 3));
        idle_w();
      end
      begin
        while (popped < 80) begin
          pull(1, 1);
          if (r_nonempty) popped++;
        end
        idle_r();
      end
    join
    repeat (3) @(negedge rclk);
    chk(exp_q.size() == 0, "R10 all words returned", exp_q.size(), 0);
    chk(empty_n == 0, "R10 empty at end", {31'd0, empty_n}, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule